// File: doc/BRIEF.md
# Synchronous Serial Receive Unit

This block is the receive half of a clocked serial port. It collects 8-bit frames from a serial data pin, either on a clock it generates itself (master mode) or on a clock and an active-low select driven by a remote device (slave mode). Each finished frame is placed in a receive data register. A full flag and a level interrupt tell software that a byte is waiting.

The data register and its full flag form the output side of the stream. `full_o` acts as valid and a pulse on `rd_i` acts as ready: the byte on `rdata_o` is taken in the cycle `rd_i` is high. A read with `full_o` low is allowed and serves as the arming read.

Back-pressure differs by mode. In master mode the generated clock stops while the register is full, so no data is lost. In slave mode the remote clock cannot be stalled, so a frame that starts while the register is full never reaches the register. If software reads partway through such a frame, the block raises a sticky conflict flag.

Top module: `ssr_top`

## Requirements
- R1: No frame is taken until `rx_en_i` is 1 and a `rd_i` pulse has occurred while `rx_en_i` is 1; dropping `rx_en_i` to 0 disarms the block again.
- R2: In master mode, while armed and `full_o` is 0, `sck_o` toggles every `div_half_i` system cycles, so its period is 2*`div_half_i` cycles. `sck_o` idles low, gives exactly 8 rising edges per frame, and `sdata_i` is sampled at each rising edge of `sck_o`.
- R3: In slave mode, bits are taken on rising edges of `sck_i` only while `ssel_n_i` is low. Pins pass through a two-stage synchronizer first. Raising `ssel_n_i` discards a partly received frame.
- R4: A frame is 8 bits, first bit received is bit 7 (MSB first). On completion it appears on `rdata_o` and `full_o` becomes 1.
- R5: `irq_o` equals `full_o` AND `irq_en_i`.
- R6: A `rd_i` pulse clears `full_o` (and thus `irq_o`) on the next cycle, unless a frame completes in that same cycle.
- R7: If a slave frame starts while `full_o` is 1 and `rd_i` occurs before its 8th bit, `conflict_o` becomes 1 when the frame ends, and the frame is not stored.
- R8: If a slave frame starts while `full_o` is 1 and no read occurs before it ends, its data is dropped: `rdata_o` keeps the earlier byte, `full_o` stays 1, and `conflict_o` stays 0.
- R9: `conflict_o` stays 1 until a `clr_conflict_i` pulse clears it; a new conflict in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive enable |
| irq_en_i | input | 1 | Receive interrupt enable |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| div_half_i | input | DIV_W (8) | Master clock half period in system cycles (0 treated as 1) |
| rd_i | input | 1 | Data register read strobe (ready) |
| rdata_o | output | FRAME_W (8) | Receive data register |
| full_o | output | 1 | Receive-full flag (valid) |
| conflict_o | output | 1 | Sticky conflict/incomplete error |
| clr_conflict_i | input | 1 | Clears the conflict flag |
| irq_o | output | 1 | Receive interrupt level |
| sck_i | input | 1 | External serial clock (slave) |
| ssel_n_i | input | 1 | Active-low select (slave) |
| sdata_i | input | 1 | Serial data in |
| sck_o | output | 1 | Generated serial clock (master) |

## Verification
A bit counter that slips shows up within one frame: `rdata_o` holds a rotated byte, or `full_o` rises one bit early or late relative to the eighth clock edge. A stale record of whether a frame began over a full register appears at the end of the next frame. It shows either as a conflict that should not exist or as an overwritten `rdata_o` where the earlier byte must survive. A wrong arming or divider state is visible before any data moves: either `sck_o` toggles when it must stay low, or a frame is accepted before the arming read.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned FRAME_W_DEF = 8;
  localparam int unsigned DIV_W_DEF   = 8;
  localparam int unsigned SYNC_N_DEF  = 2;

  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } ssr_mode_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ssr_clkgen.sv
module ssr_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_half_i,
  output logic             sck_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             active;
  logic             at_lim;

  assign active = run_i || sck_q;
  assign at_lim = ({1'b0, cnt_q} + 1'b1) >= {1'b0, div_half_i};
  assign rise_o = active && at_lim && !sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (at_lim) begin
      cnt_q <= '0;
      sck_q <= !sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !sck_q) |=> !sck_q);
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort_i,
  input  logic               bit_stb_i,
  input  logic               bit_i,
  input  logic               full_i,
  input  logic               rd_i,
  output logic               done_o,
  output logic               drop_o,
  output logic               conflict_set_o,
  output logic [FRAME_W-1:0] data_o
);
  localparam int unsigned CW = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CW-1:0]      cnt_q;
  logic               start_full_q;
  logic               read_mid_q;
  logic               read_now;

  assign read_now       = rd_i && full_i && (cnt_q != '0);
  assign done_o         = bit_stb_i && !abort_i && (cnt_q == LAST);
  assign data_o         = {sh_q[FRAME_W-2:0], bit_i};
  assign drop_o         = start_full_q;
  assign conflict_set_o = done_o && start_full_q && (read_mid_q || read_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q         <= '0;
      cnt_q        <= '0;
      start_full_q <= 1'b0;
      read_mid_q   <= 1'b0;
    end else if (abort_i) begin
      cnt_q        <= '0;
      start_full_q <= 1'b0;
      read_mid_q   <= 1'b0;
    end else begin
      if (bit_stb_i) begin
        sh_q  <= data_o;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == '0) start_full_q <= full_i;
      end
      if (done_o) read_mid_q <= 1'b0;
      else if (read_now) read_mid_q <= 1'b1;
    end
  end

  p_cnt_idle_on_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (cnt_q == '0));
endmodule

// File: rtl/ssr_top.sv
module ssr_top
  import ssr_pkg::*;
#(
  parameter int unsigned FRAME_W = FRAME_W_DEF,
  parameter int unsigned DIV_W   = DIV_W_DEF,
  parameter int unsigned SYNC_N  = SYNC_N_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en_i,
  input  logic               irq_en_i,
  input  logic               master_i,
  input  logic [DIV_W-1:0]   div_half_i,
  input  logic               rd_i,
  output logic [FRAME_W-1:0] rdata_o,
  output logic               full_o,
  output logic               conflict_o,
  input  logic               clr_conflict_i,
  output logic               irq_o,
  input  logic               sck_i,
  input  logic               ssel_n_i,
  input  logic               sdata_i,
  output logic               sck_o
);
  ssr_mode_e          mode;
  logic [2:0]         pins_s;
  logic               sck_s, sel_n_s, dat_s, sck_prev_q, s_rise;
  logic               armed_q, full_q, conflict_q;
  logic [FRAME_W-1:0] data_q;
  logic               m_run, m_rise, live, abort, bit_stb, bit_val;
  logic               done, drop, conflict_set, load;
  logic [FRAME_W-1:0] frame;

  assign mode = ssr_mode_e'(master_i);

  ssr_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sdata_i, ssel_n_i, sck_i}),
    .q_o(pins_s)
  );
  assign {dat_s, sel_n_s, sck_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else sck_prev_q <= sck_s;
  end
  assign s_rise = sck_s && !sck_prev_q;

  assign live  = armed_q && rx_en_i;
  assign m_run = live && (mode == MODE_MASTER) && !full_q;

  ssr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run_i(m_run), .div_half_i(div_half_i),
    .sck_o(sck_o), .rise_o(m_rise)
  );

  assign abort   = !live || ((mode == MODE_SLAVE) && sel_n_s);
  assign bit_stb = (mode == MODE_MASTER) ? m_rise : s_rise;
  assign bit_val = (mode == MODE_MASTER) ? sdata_i : dat_s;

  ssr_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .bit_stb_i(bit_stb),
    .bit_i(bit_val), .full_i(full_q), .rd_i(rd_i), .done_o(done),
    .drop_o(drop), .conflict_set_o(conflict_set), .data_o(frame)
  );

  assign load = done && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      full_q     <= 1'b0;
      conflict_q <= 1'b0;
      data_q     <= '0;
    end else begin
      if (!rx_en_i) armed_q <= 1'b0;
      else if (rd_i) armed_q <= 1'b1;
      if (load) begin
        full_q <= 1'b1;
        data_q <= frame;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      if (conflict_set) conflict_q <= 1'b1;
      else if (clr_conflict_i) conflict_q <= 1'b0;
    end
  end

  assign rdata_o    = data_q;
  assign full_o     = full_q;
  assign conflict_o = conflict_q;
  assign irq_o      = full_q && irq_en_i;

  p_unarmed_no_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !full_q) |=> !full_q);
  p_full_from_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(done));
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done) |=> !full_q);
  p_conflict_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conflict_q) |-> $past(done));
  p_drop_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && drop) |=> $stable(data_q));
  p_conflict_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_q && !clr_conflict_i) |=> conflict_q);
endmodule

// File: tb/ssr_top_tb.sv
module ssr_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en_i = 1'b0, irq_en_i = 1'b0, master_i = 1'b0;
  logic [7:0] div_half_i = 8'd3;
  logic       rd_i = 1'b0, clr_conflict_i = 1'b0;
  logic       sck_i = 1'b0, ssel_n_i = 1'b1, sdata_i = 1'b0;
  logic [7:0] rdata_o;
  logic       full_o, conflict_o, irq_o, sck_o;

  int n_run = 0, n_fail = 0, rises = 0;
  time t_r [2];

  always #5 clk = !clk;

  ssr_top u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .irq_en_i(irq_en_i),
    .master_i(master_i), .div_half_i(div_half_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .full_o(full_o), .conflict_o(conflict_o),
    .clr_conflict_i(clr_conflict_i), .irq_o(irq_o), .sck_i(sck_i),
    .ssel_n_i(ssel_n_i), .sdata_i(sdata_i), .sck_o(sck_o)
  );

  always @(posedge sck_o) begin
    if (rises < 2) t_r[rises] = $time;
    rises++;
  end

  // bit 8 = interrupt enable, bits 7:0 = byte to receive
  localparam logic [8:0] VEC [6] = '{
    9'h1A5, 9'h05A, 9'h1FF, 9'h000, 9'h181, 9'h07E
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic slave_bits(input logic [7:0] b, input int from, input int to);
    for (int i = from; i < to; i++) begin
      sdata_i = b[7-i];
      tick(4);
      sck_i = 1'b1;
      tick(4);
      sck_i = 1'b0;
    end
  endtask

  task automatic slave_frame(input logic [7:0] b);
    ssel_n_i = 1'b0;
    tick(4);
    slave_bits(b, 0, 8);
    tick(4);
    ssel_n_i = 1'b1;
    tick(6);
  endtask

  task automatic read_pulse();
    rd_i = 1'b1;
    tick(1);
    rd_i = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    @(negedge clk);
    check("R4 reset full", full_o, 0);
    check("R4 reset data", rdata_o, 0);
    check("R9 reset conflict", conflict_o, 0);
    check("R5 reset irq", irq_o, 0);
    check("R2 reset sck_o", sck_o, 0);

    // R1: enabled but not armed
    rx_en_i = 1'b1;
    tick(1);
    slave_frame(8'h66);
    @(negedge clk);
    check("R1 unarmed frame ignored", full_o, 0);
    tick(1);
    read_pulse();

    // R3: select high blocks reception
    ssel_n_i = 1'b1;
    tick(2);
    slave_bits(8'hC3, 0, 8);
    tick(6);
    @(negedge clk);
    check("R3 deselected ignored", full_o, 0);
    tick(1);

    // R3: partial frame aborted by deselect
    ssel_n_i = 1'b0;
    tick(4);
    slave_bits(8'hF0, 0, 4);
    ssel_n_i = 1'b1;
    tick(6);
    slave_frame(8'h3C);
    @(negedge clk);
    check("R3 abort then frame data", rdata_o, 32'h3C);
    tick(1);
    read_pulse();

    // R4/R5/R6 vector table
    foreach (VEC[k]) begin
      irq_en_i = VEC[k][8];
      slave_frame(VEC[k][7:0]);
      @(negedge clk);
      check("R4 full set", full_o, 1);
      check("R4 data MSB first", rdata_o, VEC[k][7:0]);
      check("R5 irq level", irq_o, VEC[k][8]);
      tick(1);
      read_pulse();
      @(negedge clk);
      check("R6 read clears full", full_o, 0);
      check("R5 irq drops on read", irq_o, 0);
      tick(1);
    end

    // R8: frame over full, no read -> dropped silently
    irq_en_i = 1'b1;
    slave_frame(8'h12);
    slave_frame(8'h34);
    @(negedge clk);
    check("R8 data kept", rdata_o, 32'h12);
    check("R8 full kept", full_o, 1);
    check("R8 no conflict", conflict_o, 0);
    tick(1);

    // R7: frame over full, read mid-frame -> conflict
    ssel_n_i = 1'b0;
    tick(4);
    slave_bits(8'h56, 0, 3);
    read_pulse();
    @(negedge clk);
    check("R7 no conflict before end", conflict_o, 0);
    check("R7 mid read returned old", rdata_o, 32'h12);
    tick(1);
    slave_bits(8'h56, 3, 8);
    tick(4);
    ssel_n_i = 1'b1;
    tick(6);
    @(negedge clk);
    check("R7 conflict at end", conflict_o, 1);
    check("R7 frame not stored", full_o, 0);
    tick(1);
    slave_frame(8'h9C);
    @(negedge clk);
    check("R9 conflict sticky", conflict_o, 1);
    tick(1);
    clr_conflict_i = 1'b1;
    tick(1);
    clr_conflict_i = 1'b0;
    @(negedge clk);
    check("R9 conflict cleared", conflict_o, 0);
    tick(1);
    read_pulse();

    // R1: disarm by enable low
    rx_en_i = 1'b0;
    tick(2);
    rx_en_i = 1'b1;
    tick(2);
    slave_frame(8'h77);
    @(negedge clk);
    check("R1 disarmed after enable low", full_o, 0);
    tick(1);
    read_pulse();

    // R2: master frame
    rises = 0;
    div_half_i = 8'd3;
    sdata_i = 1'b1;
    master_i = 1'b1;
    for (int i = 1; i < 8; i++) begin
      @(negedge sck_o);
      sdata_i = 8'hB4 >> (7 - i);
    end
    tick(12);
    master_i = 1'b0;
    tick(2);
    @(negedge clk);
    check("R2 master data", rdata_o, 32'hB4);
    check("R2 eight rising edges", rises, 8);
    check("R2 period", 32'(t_r[1] - t_r[0]), 60);
    check("R2 sck idle low", sck_o, 0);
    tick(1);
    read_pulse();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule